// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine with Response Watchdog

This block carries out one enhanced-parallel-port bus transfer for each host access. The host presents a one-cycle request that names the target register: the address register or the data register. It also gives the direction and, for a write, the byte to send. The engine drives the direction line, then pulls the matching strobe low and waits for the peripheral to raise its wait line. It then captures the read byte or ends the write, releases the strobe and signals completion for one cycle. The host sees a busy flag for the whole transfer.

A peripheral that never answers must not hang the host. While the engine waits for the peripheral, a counter measures the time. When 10 µs pass without an answer, the counter ends the transfer, sets a sticky timeout flag and returns all-ones as read data. The engine and its counter run only while the port mode field selects enhanced mode. Another mode ends any transfer in progress and holds the counter at zero. A separate output tells the pad logic to switch the control pins from open-drain to push-pull drive while enhanced mode is selected.

Top module: `epp_cycle_engine`

## Requirements
- R1: While reset is asserted, both strobes and the direction line are high, and busy, done, data-bus enable and the timeout flag are all low.
- R2: `pushpull_o` is high exactly when `mode_i` equals 3'b100 (enhanced mode), whether or not a transfer is running.
- R3: A request is ignored when `mode_i` is not 3'b100 or when a transfer is already in progress. Such a request starts no strobe and does not change the running transfer.
- R4: `req_addr_i`=1 selects the address strobe `astrb_n_o` and `req_addr_i`=0 selects the data strobe `dstrb_n_o`. Only the selected strobe goes low, and the two strobes are never low together.
- R5: For a write (`req_wr_i`=1), `write_n_o` is low and `pd_oe_o` is high with `pd_o` holding the request byte for the whole busy period. For a read, `write_n_o` stays high and `pd_oe_o` stays low.
- R6: The strobe goes low only after the synchronised wait line is seen low. Once wait is seen high, the strobe is released, `done_o` pulses for one cycle and busy falls in the next cycle.
- R7: A successful read returns on `rdata_o` the byte present on `pd_i` when wait was seen high. A successful write leaves `rdata_o` unchanged.
- R8: If wait is not seen high within TMO = CLK_MHZ × TMO_US cycles (1250 by default), the transfer ends with busy high for exactly TMO+1 cycles. `done_o` pulses, `tmo_flag_o` sets and `rdata_o` becomes 8'hFF.
- R9: `tmo_flag_o` stays set until a cycle with `tmo_clr_i` high. If a timeout and a clear fall in the same cycle, the flag ends up set. A new transfer may start and complete while the flag is set.
- R10: When the synchronised wait line is first seen high in the same cycle as the timer expires, the transfer counts as successful: the read byte is captured and the flag stays clear.
- R11: When `mode_i` leaves 3'b100 during a transfer, the next cycle shows busy low, both strobes and the direction line high and the bus enable low, with no done pulse. The timeout counter stays at zero, so no timeout flag is raised later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 3 | Port mode field; 3'b100 selects enhanced mode |
| req_i | input | 1 | One-cycle host access request |
| req_addr_i | input | 1 | 1 = address register access, 0 = data register access |
| req_wr_i | input | 1 | 1 = host write, 0 = host read |
| wdata_i | input | 8 | Byte to write |
| tmo_clr_i | input | 1 | Clears the timeout flag |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse, success or timeout |
| rdata_o | output | 8 | Last read byte, or 8'hFF after a timeout |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| pd_o | output | 8 | Data bus output value |
| pd_oe_o | output | 1 | Data bus output enable |
| pd_i | input | 8 | Data bus input value |
| write_n_o | output | 1 | Direction line, low for writes |
| dstrb_n_o | output | 1 | Data strobe, active low |
| astrb_n_o | output | 1 | Address strobe, active low |
| wait_i | input | 1 | Peripheral wait line, high means ready |
| pushpull_o | output | 1 | Push-pull drive enable for the control pins |

## Verification
Two events can land on the same clock edge: the peripheral's answer can arrive in the cycle where the watchdog reaches its limit, and a host clear can coincide with the watchdog setting the flag. The bench counts busy cycles from the setup cycle. It raises wait exactly three cycles before expiry, so that the two-stage synchroniser delivers it on the expiry edge, and expects a clean read. It then raises wait one cycle later and expects a timeout with 8'hFF. For the flag race, the clear is held high through a whole timed-out transfer, and the flag must be set afterwards.

// File: rtl/epp_engine_pkg.sv
package epp_engine_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RELEASE = 2'd3
  } epp_state_e;

  localparam logic [2:0] MODE_EPP = 3'b100;

endpackage

// File: rtl/epp_rst_sync.sv
module epp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/epp_sync_chain.sv
module epp_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= 1'b0;
          else        stg_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= 1'b0;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/epp_timeout_timer.sv
module epp_timeout_timer #(
  parameter int unsigned LIMIT = 1250,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  output logic          expire_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run_i)              cnt_d = '0;
    else if (cnt_q == LAST)  cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == LAST);
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_engine_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          epp_en_i,
  input  logic          req_i,
  input  logic          req_addr_i,
  input  logic          req_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] pd_i,
  input  logic          wait_s_i,
  input  logic          expire_i,
  input  logic          tmo_clr_i,
  output logic          tmr_run_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          write_n_o,
  output logic          astrb_n_o,
  output logic          dstrb_n_o,
  output logic          pd_oe_o,
  output logic [DW-1:0] pd_o,
  output logic [DW-1:0] rdata_o,
  output logic          tmo_flag_o
);

  epp_state_e    state_q, state_d;
  logic          dir_wr_q, sel_addr_q;
  logic [DW-1:0] wdata_q, rdata_q, rdata_d;
  logic          flag_q, flag_d;
  logic          start, in_wait, ack, tmo_hit, tmo_set, rd_ok;

  // next-state and datapath selection
  always_comb begin
    start   = epp_en_i && req_i && (state_q == ST_IDLE);
    in_wait = (state_q == ST_SETUP) || (state_q == ST_STROBE);
    ack     = (state_q == ST_STROBE) && wait_s_i;
    tmo_hit = in_wait && expire_i && !ack;   // a late answer wins on the expiry edge
    tmo_set = epp_en_i && tmo_hit;
    rd_ok   = epp_en_i && ack && !dir_wr_q;

    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_SETUP;
      ST_SETUP: begin
        if (tmo_hit)        state_d = ST_RELEASE;
        else if (!wait_s_i) state_d = ST_STROBE;
      end
      ST_STROBE:  if (ack || tmo_hit) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    if (!epp_en_i) state_d = ST_IDLE;

    if (tmo_set)    rdata_d = '1;
    else if (rd_ok) rdata_d = pd_i;
    else            rdata_d = rdata_q;

    if (tmo_set)        flag_d = 1'b1;
    else if (tmo_clr_i) flag_d = 1'b0;
    else                flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rdata_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rdata_q <= rdata_d;
      flag_q  <= flag_d;
    end
  end

  // request capture, enabled only when a transfer starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_wr_q   <= 1'b0;
      sel_addr_q <= 1'b0;
      wdata_q    <= '0;
    end else if (start) begin
      dir_wr_q   <= req_wr_i;
      sel_addr_q <= req_addr_i;
      wdata_q    <= wdata_i;
    end
  end

  assign tmr_run_o  = epp_en_i && in_wait;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_RELEASE);
  assign write_n_o  = !(busy_o && dir_wr_q);
  assign pd_oe_o    = busy_o && dir_wr_q;
  assign pd_o       = wdata_q;
  assign astrb_n_o  = !((state_q == ST_STROBE) && sel_addr_q);
  assign dstrb_n_o  = !((state_q == ST_STROBE) && !sel_addr_q);
  assign rdata_o    = rdata_q;
  assign tmo_flag_o = flag_q;

endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
  import epp_engine_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int TMO_US      = 10,
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_i,
  input  logic          req_i,
  input  logic          req_addr_i,
  input  logic          req_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tmo_clr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          tmo_flag_o,
  output logic [DW-1:0] pd_o,
  output logic          pd_oe_o,
  input  logic [DW-1:0] pd_i,
  output logic          write_n_o,
  output logic          dstrb_n_o,
  output logic          astrb_n_o,
  input  logic          wait_i,
  output logic          pushpull_o
);

  localparam int unsigned TMO_CYCLES = CLK_MHZ * TMO_US;
  localparam int          TMO_CW     = $clog2(TMO_CYCLES + 1);

  logic              rst_sync_n;
  logic              epp_en;
  logic              wait_s;
  logic              tmr_run;
  logic              tmo_expire;
  logic [TMO_CW-1:0] tmo_cnt;

  assign epp_en     = (mode_i == MODE_EPP);
  assign pushpull_o = epp_en;

  epp_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  epp_sync_chain #(.STAGES(SYNC_STAGES)) u_wait_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (wait_i),
    .q_o   (wait_s)
  );

  epp_timeout_timer #(.LIMIT(TMO_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run_i    (tmr_run),
    .expire_o (tmo_expire),
    .cnt_o    (tmo_cnt)
  );

  epp_cycle_fsm #(.DW(DW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .epp_en_i   (epp_en),
    .req_i      (req_i),
    .req_addr_i (req_addr_i),
    .req_wr_i   (req_wr_i),
    .wdata_i    (wdata_i),
    .pd_i       (pd_i),
    .wait_s_i   (wait_s),
    .expire_i   (tmo_expire),
    .tmo_clr_i  (tmo_clr_i),
    .tmr_run_o  (tmr_run),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .write_n_o  (write_n_o),
    .astrb_n_o  (astrb_n_o),
    .dstrb_n_o  (dstrb_n_o),
    .pd_oe_o    (pd_oe_o),
    .pd_o       (pd_o),
    .rdata_o    (rdata_o),
    .tmo_flag_o (tmo_flag_o)
  );

endmodule

// File: rtl/epp_cycle_engine_chk.sv
module epp_cycle_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic       tmo_clr_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       tmo_flag_o,
  input logic       pd_oe_o,
  input logic       write_n_o,
  input logic       astrb_n_o,
  input logic       dstrb_n_o,
  input logic       tmo_zero
);

  // R4: never both strobes active
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!astrb_n_o && !dstrb_n_o));

  // R5: write direction only inside a transfer, with the bus driven
  a_r5_write_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !write_n_o |-> (busy_o && pd_oe_o));

  // R6: completion is a single-cycle pulse followed by idle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R8: the flag is only raised together with a completion
  a_r8_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag_o) |-> done_o);

  // R9: the flag holds without a clear
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag_o && !tmo_clr_i) |=> tmo_flag_o);

  // R11: outside enhanced mode the engine idles and the timer stays at zero
  a_r11_mode_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 3'b100) |=> (!busy_o && tmo_zero));

endmodule

bind epp_cycle_engine epp_cycle_engine_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .tmo_clr_i  (tmo_clr_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .tmo_flag_o (tmo_flag_o),
  .pd_oe_o    (pd_oe_o),
  .write_n_o  (write_n_o),
  .astrb_n_o  (astrb_n_o),
  .dstrb_n_o  (dstrb_n_o),
  .tmo_zero   (tmo_cnt == '0)
);

// File: tb/epp_cycle_engine_tb_top.sv
`timescale 1ns/1ps
module epp_cycle_engine_tb_top;

  localparam int TMO = 125 * 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode_i;
  logic       req_i, req_addr_i, req_wr_i, tmo_clr_i, wait_i;
  logic [7:0] wdata_i, pd_i;
  logic       busy_o, done_o, tmo_flag_o, pd_oe_o, write_n_o, dstrb_n_o, astrb_n_o, pushpull_o;
  logic [7:0] rdata_o, pd_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  epp_cycle_engine dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .req_i(req_i), .req_addr_i(req_addr_i),
    .req_wr_i(req_wr_i), .wdata_i(wdata_i), .tmo_clr_i(tmo_clr_i), .busy_o(busy_o),
    .done_o(done_o), .rdata_o(rdata_o), .tmo_flag_o(tmo_flag_o), .pd_o(pd_o),
    .pd_oe_o(pd_oe_o), .pd_i(pd_i), .write_n_o(write_n_o), .dstrb_n_o(dstrb_n_o),
    .astrb_n_o(astrb_n_o), .wait_i(wait_i), .pushpull_o(pushpull_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rdata(input logic [7:0] prev, input bit wr,
                                           input bit tmo, input logic [7:0] pin);
    if (tmo)     return 8'hFF;
    else if (wr) return prev;
    else         return pin;
  endfunction

  function automatic int exp_tmo_busy();
    return TMO + 1;
  endfunction

  int  r_busy;
  bit  r_done, r_lines, r_strobe;

  // resp_dly >= 0: raise wait after resp_dly+1 cycles of strobe low
  // force_b  >= 0: raise wait in busy cycle force_b; abort_b >= 0: leave mode there
  task automatic run_cycle(input bit wr, input bit adr, input logic [7:0] wd,
                           input logic [7:0] pin, input int resp_dly, input int force_b,
                           input int abort_b, input bit poke, input bit hold_clr);
    int b, sl;
    logic sel, oth;
    @(negedge clk);
    req_i = 1; req_wr_i = wr; req_addr_i = adr; wdata_i = wd; pd_i = pin; tmo_clr_i = hold_clr;
    @(negedge clk);
    req_i = 0; req_wr_i = ~wr; wdata_i = ~wd;
    b = 0; sl = 0; r_busy = 0; r_done = 0; r_lines = 1; r_strobe = 0;
    for (int g = 0; g < 4000; g++) begin
      if (!busy_o) break;
      r_busy++;
      sel = adr ? astrb_n_o : dstrb_n_o;
      oth = adr ? dstrb_n_o : astrb_n_o;
      if (write_n_o !== ~wr || pd_oe_o !== wr || oth !== 1'b1) r_lines = 0;
      if (wr && pd_o !== wd) r_lines = 0;
      if (sel === 1'b0) begin
        sl++; r_strobe = 1;
        if (resp_dly >= 0 && sl == resp_dly + 1) wait_i = 1;
      end
      if (force_b == b) wait_i = 1;
      if (poke && b == 1) begin
        req_i = 1; req_addr_i = ~adr; req_wr_i = ~wr;
      end else req_i = 0;
      if (abort_b == b) mode_i = 3'b000;
      if (done_o) begin
        r_done = 1; wait_i = 0; tmo_clr_i = 0;
      end
      b++;
      @(negedge clk);
    end
    req_i = 0; wait_i = 0; tmo_clr_i = 0;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] prev, pin, wd;
    bit wr, adr;
    int dly, ok;
    void'($urandom(32'h1284_5EED));
    rst_n = 0; mode_i = 3'b100; req_i = 0; req_addr_i = 0; req_wr_i = 0;
    wdata_i = 0; pd_i = 0; tmo_clr_i = 0; wait_i = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(astrb_n_o && dstrb_n_o && write_n_o && !busy_o && !done_o && !tmo_flag_o && !pd_oe_o,
          "R1 reset outputs", {astrb_n_o, dstrb_n_o, write_n_o, busy_o, done_o, tmo_flag_o, pd_oe_o},
          7'b1110000);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R2 drive mode
    check(pushpull_o == 1'b1, "R2 pushpull in enhanced mode", pushpull_o, 1);
    mode_i = 3'b011; @(negedge clk);
    check(pushpull_o == 1'b0, "R2 pushpull other mode", pushpull_o, 0);
    // R3 request outside enhanced mode
    mode_i = 3'b000; req_i = 1; req_addr_i = 1; @(negedge clk); req_i = 0;
    ok = 1;
    repeat (4) begin
      if (busy_o || !astrb_n_o || !dstrb_n_o || !write_n_o) ok = 0;
      @(negedge clk);
    end
    check(ok == 1, "R3 ignored outside mode", ok, 1);
    mode_i = 3'b100; @(negedge clk);

    // R4 R6 R7 directed read of address register
    prev = rdata_o;
    run_cycle(0, 1, 8'h00, 8'h5A, 3, -1, -1, 0, 0);
    check(r_done && r_strobe && r_lines, "R4 address strobe read", {r_done, r_strobe, r_lines}, 3'b111);
    check(rdata_o == exp_rdata(prev, 0, 0, 8'h5A), "R7 read data", rdata_o, 8'h5A);
    check(!busy_o && !tmo_flag_o, "R6 idle after done", {busy_o, tmo_flag_o}, 0);
    // R5 directed write of data register
    prev = rdata_o;
    run_cycle(1, 0, 8'hC3, 8'h11, 0, -1, -1, 0, 0);
    check(r_done && r_strobe && r_lines, "R5 data strobe write", {r_done, r_strobe, r_lines}, 3'b111);
    check(rdata_o == exp_rdata(prev, 1, 0, 8'h11), "R7 write keeps rdata", rdata_o, prev);
    // R3 request while busy
    run_cycle(0, 0, 8'h00, 8'h96, 5, -1, -1, 1, 0);
    ok = 1;
    repeat (4) begin
      if (busy_o) ok = 0;
      @(negedge clk);
    end
    check(ok == 1 && r_lines && rdata_o == 8'h96, "R3 ignored while busy", {ok, rdata_o}, {1'b1, 8'h96});

    // random transfers
    for (int i = 0; i < 40; i++) begin
      wr = $urandom_range(1); adr = $urandom_range(1);
      wd = 8'($urandom); pin = 8'($urandom); dly = $urandom_range(15);
      prev = rdata_o;
      run_cycle(wr, adr, wd, pin, dly, -1, -1, 0, 0);
      check(r_done && r_strobe && r_lines && !tmo_flag_o, "R6 random handshake",
            {r_done, r_strobe, r_lines, tmo_flag_o}, 4'b1110);
      check(rdata_o == exp_rdata(prev, wr, 0, pin), "R7 random rdata", rdata_o,
            exp_rdata(prev, wr, 0, pin));
    end

    // R8 timeout
    run_cycle(0, 0, 8'h00, 8'h42, -1, -1, -1, 0, 0);
    check(r_busy == exp_tmo_busy(), "R8 timeout busy length", r_busy, exp_tmo_busy());
    check(r_done && tmo_flag_o && rdata_o == 8'hFF, "R8 timeout flag and data",
          {r_done, tmo_flag_o, rdata_o}, {2'b11, 8'hFF});
    // R9 new transfer while flag set
    run_cycle(1, 1, 8'h3C, 8'h00, 2, -1, -1, 0, 0);
    check(r_done && tmo_flag_o, "R9 cycle with flag set", {r_done, tmo_flag_o}, 2'b11);
    @(negedge clk); tmo_clr_i = 1; @(negedge clk); tmo_clr_i = 0;
    check(!tmo_flag_o, "R9 flag cleared", tmo_flag_o, 0);
    // R9 clear held across the setting edge
    run_cycle(1, 0, 8'h77, 8'h00, -1, -1, -1, 0, 1);
    @(negedge clk);
    check(tmo_flag_o, "R9 set beats clear", tmo_flag_o, 1);
    tmo_clr_i = 1; @(negedge clk); tmo_clr_i = 0; @(negedge clk);

    // R10 answer on the expiry edge wins
    run_cycle(0, 1, 8'h00, 8'h3C, -1, TMO - 3, -1, 0, 0);
    check(!tmo_flag_o && rdata_o == 8'h3C && r_busy == exp_tmo_busy(), "R10 late answer accepted",
          {tmo_flag_o, rdata_o}, {1'b0, 8'h3C});
    run_cycle(0, 1, 8'h00, 8'h3C, -1, TMO - 2, -1, 0, 0);
    check(tmo_flag_o && rdata_o == 8'hFF, "R10 one cycle too late", {tmo_flag_o, rdata_o}, {1'b1, 8'hFF});
    tmo_clr_i = 1; @(negedge clk); tmo_clr_i = 0; @(negedge clk);

    // R11 mode exit mid transfer
    run_cycle(1, 0, 8'hA5, 8'h00, -1, -1, 5, 0, 0);
    check(r_busy == 6 && !r_done, "R11 abort timing", r_busy, 6);
    check(astrb_n_o && dstrb_n_o && write_n_o && !pd_oe_o, "R11 lines released",
          {astrb_n_o, dstrb_n_o, write_n_o, pd_oe_o}, 4'b1110);
    repeat (TMO + 50) @(negedge clk);
    check(!tmo_flag_o && !busy_o, "R11 timer held off", {tmo_flag_o, busy_o}, 0);
    mode_i = 3'b100; @(negedge clk);
    prev = rdata_o;
    run_cycle(0, 0, 8'h00, 8'hE1, 1, -1, -1, 0, 0);
    check(r_done && rdata_o == 8'hE1, "R11 recovery read", rdata_o, 8'hE1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule